// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a clocked on-chip request bus to an external asynchronous static RAM of 256K sixteen-bit words. Each word has two byte lanes, and each lane has its own active-low strobe. A request carries an address, a write flag, write data and a two-bit lane mask. The block turns each accepted request into one memory access. All timing intervals of that access are counted in clock cycles.

The controller accepts one request at a time, and only while `req_ready_o` is high. Every memory-side pin comes straight from a flop. When the controller is idle, it holds every memory control line inactive and stops driving the data bus. It drives write data only after the memory has had time to release the bus following a read. A read returns its data with a single-cycle valid pulse.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every cycle in which `req_ready_o` is high, `mem_cs_no`, `mem_we_no`, `mem_oe_no`, `mem_ub_no` and `mem_lb_no` are high and `mem_dq_oe_o` is low.
- R2: An accepted write with a non-zero lane mask holds `mem_we_no` and `mem_cs_no` low together for exactly WE_PULSE_CYC cycles, with `mem_oe_no` high. Throughout that pulse `mem_dq_oe_o` is high and `mem_dq_o` equals the request's write data.
- R3: A write takes exactly WR_CYCLE_CYC cycles from the first cycle with `mem_we_no` low to the first cycle with `req_ready_o` high again (9 + 2 = 11 with the defaults).
- R4: An accepted read with a non-zero lane mask holds `mem_cs_no` and `mem_oe_no` low for exactly RD_ACC_CYC cycles, with `mem_we_no` high and `mem_dq_oe_o` low.
- R5: Read data is sampled from `mem_dq_i` at the end of the last output-enable cycle. `rsp_valid_o` is then high for one cycle only, RD_ACC_CYC+1 cycles after the accepting edge, with the sampled word on `rsp_rdata_o`.
- R6: `mem_dq_oe_o` is never high while `mem_oe_no` is low. It rises only after `mem_oe_no` has been high for at least TURN_CYC consecutive cycles.
- R7: A request with lane mask 2'b00 is accepted, causes no memory access (`mem_cs_no` stays high) and leaves `req_ready_o` high.
- R8: `req_valid_i` is ignored while `req_ready_o` is low, and such a request causes no access at any time later.
- R9: While `mem_cs_no` is low, `mem_lb_no` is the inverse of lane-mask bit 0, which gates data bits 7:0, and `mem_ub_no` is the inverse of bit 1, which gates bits 15:8.
- R10: `mem_addr_o` equals the accepted address and stays stable in every cycle with `mem_cs_no` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready_o | output | 1 | Controller idle, request taken this cycle |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 16 | Read data |
| mem_cs_no | output | 1 | Memory select, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_ub_no | output | 1 | High-lane strobe, active low |
| mem_lb_no | output | 1 | Low-lane strobe, active low |
| mem_addr_o | output | 18 | Memory address |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The hardest situation to reach is a write that is accepted in the first idle cycle after a read. Only then does the turnaround wait actually stall the write. The stimulus makes this case directly and also through random read/write mixes whose requests are issued as soon as ready returns. A second hard case is a request presented while the controller is busy. The bench raises valid in the middle of a write pulse, then reads the targeted word back to show that it was left untouched. The bench memory model returns junk until 55 ns of enabled read have elapsed, so a capture that comes too early shows up as wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WPUL,
    ST_WREC,
    ST_RACC
  } state_e;

  typedef struct packed {
    logic             cs_n;
    logic             we_n;
    logic             oe_n;
    logic [LANES-1:0] bs_n;
    logic             dq_oe;
  } pins_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic pins_t pins_for(state_e st, logic [LANES-1:0] be);
    pins_t p;
    p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, bs_n: '1, dq_oe: 1'b0};
    case (st)
      ST_WPUL: begin
        p.cs_n  = 1'b0;
        p.we_n  = 1'b0;
        p.bs_n  = ~be;
        p.dq_oe = 1'b1;
      end
      ST_WREC: p.dq_oe = 1'b1;  // data hold past strobe release
      ST_RACC: begin
        p.cs_n = 1'b0;
        p.oe_n = 1'b0;
        p.bs_n = ~be;
      end
      default: ;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/asram_turn.sv
module asram_turn #(
  parameter int unsigned TURN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_n_i,
  output logic quiet_o
);
  localparam int unsigned CW = $clog2(TURN_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(TURN_CYC);
  localparam logic [CW-1:0] LIM = CW'(TURN_CYC - 1);

  logic [CW-1:0] hi_q;  // completed oe-high cycles, saturating

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_q <= SAT;
    else if (!oe_n_i)  hi_q <= '0;
    else if (hi_q < SAT) hi_q <= hi_q + 1'b1;
  end

  // current high cycle counts toward the gap
  assign quiet_o = oe_n_i && (hi_q >= LIM);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W       = 18,
  parameter int unsigned WE_PULSE_CYC = 9,
  parameter int unsigned WR_CYCLE_CYC = 11,
  parameter int unsigned RD_ACC_CYC   = 12,
  parameter int unsigned TURN_CYC     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [8*LANES-1:0]  req_wdata_i,
  input  logic [LANES-1:0]    req_be_i,
  output logic                req_ready_o,
  output logic                rsp_valid_o,
  output logic [8*LANES-1:0]  rsp_rdata_o,
  output logic                mem_cs_no,
  output logic                mem_we_no,
  output logic                mem_oe_no,
  output logic                mem_ub_no,
  output logic                mem_lb_no,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [8*LANES-1:0]  mem_dq_o,
  output logic                mem_dq_oe_o,
  input  logic [8*LANES-1:0]  mem_dq_i
);
  localparam int unsigned DATA_W   = 8 * LANES;
  localparam int unsigned WREC_CYC = (WR_CYCLE_CYC > WE_PULSE_CYC + 1) ?
                                     (WR_CYCLE_CYC - WE_PULSE_CYC) : 1;
  localparam int unsigned CNT_MAX  = max2(max2(WE_PULSE_CYC, WREC_CYC), RD_ACC_CYC);
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

  state_e              state_q, state_d;
  pins_t               pins_q, pins_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic [LANES-1:0]    be_q, be_d;
  logic                rvalid_q;
  logic                accept, load;
  logic [CNT_W-1:0]    load_val;
  logic                cnt_zero, quiet;

  asram_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .zero_o (cnt_zero)
  );

  asram_turn #(.TURN_CYC(TURN_CYC)) u_turn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oe_n_i  (pins_q.oe_n),
    .quiet_o (quiet)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_ready_o && req_valid_i && (req_be_i != '0);
  assign be_d        = accept ? req_be_i : be_q;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (!req_write_i) begin
          state_d  = ST_RACC;
          load     = 1'b1;
          load_val = CNT_W'(RD_ACC_CYC - 1);
        end else if (quiet) begin
          state_d  = ST_WPUL;
          load     = 1'b1;
          load_val = CNT_W'(WE_PULSE_CYC - 1);
        end else begin
          state_d  = ST_TURN;
        end
      end
      ST_TURN: if (quiet) begin
        state_d  = ST_WPUL;
        load     = 1'b1;
        load_val = CNT_W'(WE_PULSE_CYC - 1);
      end
      ST_WPUL: if (cnt_zero) begin
        state_d  = ST_WREC;
        load     = 1'b1;
        load_val = CNT_W'(WREC_CYC - 1);
      end
      ST_WREC: if (cnt_zero) state_d = ST_IDLE;
      ST_RACC: if (cnt_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    pins_d = pins_for(state_d, be_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pins_q   <= pins_for(ST_IDLE, '0);
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pins_q   <= pins_d;
      rvalid_q <= 1'b0;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
      end
      if (state_q == ST_RACC && cnt_zero) begin
        rdata_q  <= mem_dq_i;
        rvalid_q <= 1'b1;
      end
    end
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;
  assign mem_cs_no   = pins_q.cs_n;
  assign mem_we_no   = pins_q.we_n;
  assign mem_oe_no   = pins_q.oe_n;
  assign mem_lb_no   = pins_q.bs_n[0];
  assign mem_ub_no   = pins_q.bs_n[1];
  assign mem_dq_oe_o = pins_q.dq_oe;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned TURN_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              mem_cs_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_ub_no,
  input logic              mem_lb_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_dq_oe_o
);
  int unsigned hi_q;
  logic        dq_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= TURN_CYC;
      dq_oe_q <= 1'b0;
    end else begin
      dq_oe_q <= mem_dq_oe_o;
      if (!mem_oe_no)          hi_q <= 0;
      else if (hi_q < TURN_CYC) hi_q <= hi_q + 1;
    end
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_no && mem_we_no && mem_oe_no && mem_ub_no && mem_lb_no && !mem_dq_oe_o));
  // R2
  we_inside_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs_no && mem_oe_no && !(mem_ub_no && mem_lb_no) && mem_dq_oe_o));
  // R4
  oe_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_cs_no && mem_we_no && !mem_dq_oe_o));
  // R5
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R6
  no_drive_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);
  // R6
  turn_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && !dq_oe_q) |-> (hi_q >= TURN_CYC));
  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_cs_no   (mem_cs_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_ub_no   (mem_ub_no),
  .mem_lb_no   (mem_lb_no),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;
  localparam int WP = 9, WC = 11, RA = 12, TC = 4, ACC_MEM = 11;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        ready, rvalid, cs_n, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [15:0] rdata, dq_o;
  logic [15:0] dq_i = 16'hBAD0;
  logic [17:0] maddr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [17:0] cur_addr = '0;
  logic [15:0] cur_data = '0;
  logic [1:0]  cur_be = '0;
  logic [15:0] mem_m [logic [17:0]];
  logic [15:0] ref_m [logic [17:0]];

  always #2.5 clk = ~clk;

  asram_ctrl #(.WE_PULSE_CYC(WP), .WR_CYCLE_CYC(WC), .RD_ACC_CYC(RA), .TURN_CYC(TC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be),
    .req_ready_o(ready), .rsp_valid_o(rvalid), .rsp_rdata_o(rdata),
    .mem_cs_no(cs_n), .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_ub_no(ub_n), .mem_lb_no(lb_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i));

  function automatic logic [15:0] dflt(logic [17:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] lanes(logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // pin monitor and memory model, both on the falling edge
  int we_run = 0, oe_run = 0, hi_run = 100, wc = 0, rd_age = 0;
  logic p_we = 1, p_oe = 1, p_dqoe = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!we_n) we_run++;
      else if (!p_we) begin chk(we_run == WP, "R2 pulse", we_run, WP); we_run = 0; end
      if (!oe_n) oe_run++;
      else if (!p_oe) begin chk(oe_run == RA, "R4 oe length", oe_run, RA); oe_run = 0; end
      if (!cs_n) begin
        chk({ub_n, lb_n} == ~cur_be, "R9 lanes", {ub_n, lb_n}, ~cur_be);
        chk(maddr == cur_addr, "R10 addr", maddr, cur_addr);
      end
      if (dq_oe) begin
        chk(oe_n, "R6 drive in read", oe_n, 1);
        if (!p_dqoe) chk(hi_run >= TC, "R6 turnaround", hi_run, TC);
      end
      if (!we_n) chk(dq_oe && dq_o == cur_data, "R2 data", dq_o, cur_data);
      if (!we_n && p_we) wc = 1;
      else if (wc > 0 && !ready) wc++;
      else if (wc > 0 && ready) begin chk(wc == WC, "R3 write cycle", wc, WC); wc = 0; end
      hi_run = oe_n ? hi_run + 1 : 0;
      p_we = we_n; p_oe = oe_n; p_dqoe = dq_oe;
      // memory model
      if (!cs_n && !we_n) begin
        logic [15:0] old, nw;
        old = mem_m.exists(maddr) ? mem_m[maddr] : dflt(maddr);
        nw  = dq_oe ? dq_o : 16'hDEAD;
        if (!lb_n) old[7:0]  = nw[7:0];
        if (!ub_n) old[15:8] = nw[15:8];
        mem_m[maddr] = old;
      end
      if (!cs_n && !oe_n && we_n) rd_age++; else rd_age = 0;
      if (rd_age >= ACC_MEM) begin
        logic [15:0] w;
        w = mem_m.exists(maddr) ? mem_m[maddr] : dflt(maddr);
        dq_i = {ub_n ? 8'hEE : w[15:8], lb_n ? 8'hEE : w[7:0]};
      end else dq_i = 16'hBAD0 ^ 16'(rd_age);
    end
  end

  // called at a falling edge
  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    int n;
    while (!ready) @(negedge clk);
    if (be != 0) begin cur_addr = a; cur_data = d; cur_be = be; end
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    if (be == 0) begin
      chk(ready && cs_n, "R7 empty mask", {ready, cs_n}, 2'b11);
      @(negedge clk);
      chk(ready && cs_n, "R7 no access", {ready, cs_n}, 2'b11);
    end else if (wr) begin
      logic [15:0] old;
      old = ref_m.exists(a) ? ref_m[a] : dflt(a);
      ref_m[a] = (old & ~lanes(be)) | (d & lanes(be));
    end else begin
      logic [15:0] exp;
      n = 1;
      while (!rvalid && n < 60) begin @(negedge clk); n++; end
      chk(n == RA + 1, "R5 latency", n, RA + 1);
      exp = ref_m.exists(a) ? ref_m[a] : dflt(a);
      chk((rdata & lanes(be)) == (exp & lanes(be)), "R5 data", rdata & lanes(be), exp & lanes(be));
      @(negedge clk);
      chk(!rvalid, "R5 single pulse", rvalid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd7301));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready && cs_n && we_n && oe_n && ub_n && lb_n && !dq_oe && !rvalid, "R1 reset",
        {ready, cs_n, we_n, oe_n, ub_n, lb_n, dq_oe, rvalid}, 8'b11111100);
    // directed
    issue(1, 18'h00003, 16'h1234, 2'b11);
    issue(0, 18'h00003, 16'h0, 2'b11);
    issue(1, 18'h00003, 16'hAB00, 2'b10);  // read-to-write turnaround
    issue(0, 18'h00003, 16'h0, 2'b11);
    issue(1, 18'h00003, 16'h00CD, 2'b01);
    issue(0, 18'h00003, 16'h0, 2'b01);
    issue(0, 18'h00003, 16'h0, 2'b10);
    issue(1, 18'h00003, 16'hFFFF, 2'b00);  // R7
    issue(0, 18'h00003, 16'h0, 2'b11);
    issue(0, 18'h3FFFF, 16'h0, 2'b11);
    // R8: request while busy
    issue(1, 18'h00004, 16'h5555, 2'b11);
    req_valid = 1; req_write = 1; req_addr = 18'h00100; req_wdata = 16'h9999; req_be = 2'b11;
    repeat (3) begin
      @(negedge clk);
      chk(!ready, "R8 busy", ready, 0);
    end
    req_valid = 0;
    issue(0, 18'h00100, 16'h0, 2'b11);
    chk(!ref_m.exists(18'h00100) && !mem_m.exists(18'h00100), "R8 ignored write", 0, 0);
    // random mix
    for (int i = 0; i < 250; i++) begin
      logic [17:0] a;
      a = (($urandom % 2) != 0 ? 18'h3FFF0 : 18'h0) | 18'($urandom % 16);
      issue(($urandom % 2) != 0, a, 16'($urandom), 2'($urandom));
    end
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule